// File: doc/BRIEF.md
# Double-Buffered SPI Slave Transmitter

This block is an SPI slave for 8-bit frames in mode 0 with one active-low chip select. A host writes outgoing bytes into a one-byte holding register. The holding register feeds a transmit shift register that the external master clocks out, MSB first. Bytes clocked in on MOSI are collected into a receive data register, and the host fetches them through a read strobe. The serial pins are sampled by the system clock through two-flop synchronisers, and all state runs in that one clock domain.

Three status outputs show the transmit side. One shows that the holding register can take a byte. One shows that the whole transmitter (holding register and shift register) has drained. A handshake output tells the master that slave data is waiting. The drained flag returns high once the last queued byte has been completely clocked out. The handshake output follows the drained flag, so it cannot drop while the final byte is still in the shift register. A master that polls the handshake therefore never sees it fall before it has read every queued byte. When nothing is queued, the slave sends all-ones bytes.

Top module: `spi_dbuf_slave`

## Requirements
- R1: After reset, tx_hold_empty=1, tx_all_empty=1, data_pending=0, rx_ready=0, rx_overrun=0 and spi_miso=1.
- R2: A host write clears tx_all_empty and sets data_pending in the cycle after the write strobe.
- R3: A byte written while the shift register is free and no byte is in progress moves directly into the shift register. In the cycle after the write, tx_hold_empty=1 and tx_all_empty=0.
- R4: A byte written while the shift register is loaded, or while a frame is part-way through, stays in the holding register and tx_hold_empty stays 0.
- R5: At the end of a byte (8th rising SCK), a held byte moves into the shift register and tx_hold_empty returns to 1. Bytes go out MSB first: the MSB is on MISO before the first rising SCK, and MISO changes only after falling SCK edges.
- R6: A host write while the holding register is full is ignored.
- R7: When the last queued byte finishes (its 8th rising SCK) and the holding register is empty, tx_all_empty returns to 1 and data_pending drops. Before that point, data_pending stays 1 for the whole of that byte.
- R8: A byte clocked out with nothing queued reads as 0xFF.
- R9: Received bytes are assembled MSB first from MOSI sampled on rising SCK. On the 8th rising edge the byte appears on host_rdata and rx_ready is set.
- R10: A host_rd strobe clears rx_ready and rx_overrun. A byte that completes while rx_ready is still set, with no read in that cycle, sets rx_overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the transmit byte |
| host_wdata | input | 8 | Byte to transmit |
| host_rd | input | 1 | Read strobe; acknowledges the received byte |
| host_rdata | output | 8 | Last received byte |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to the master |
| tx_hold_empty | output | 1 | Holding register can accept a byte |
| tx_all_empty | output | 1 | Holding and shift registers both drained |
| rx_ready | output | 1 | Unread received byte available |
| rx_overrun | output | 1 | A received byte arrived before the previous one was read |
| data_pending | output | 1 | Handshake to the master: slave data queued |

## Verification
Host-side results are registered, so the transmit flags reflect a write strobe one clock after it and rx_ready clears one clock after host_rd. The bench therefore samples them at the falling edge that follows the strobe. A serial pin change passes two synchroniser flops and an edge-detect flop, so shift, flag and MISO changes come three clocks after a SCK edge. The bench holds each SCK phase for six clocks and samples MISO at the end of the low phase, when it has settled. The receive result, the frame-end transmit flags and overrun are checked after chip select has returned high, well past the three-clock delay. data_pending is captured just before the last rising SCK of every frame to show it had not yet dropped.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  // Serial events seen in the system clock domain
  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic cs_act;
    logic mosi;
  } spi_evt_t;
endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_i,
  input  logic                  mosi_i,
  input  logic                  cs_n_i,
  output spi_dbuf_pkg::spi_evt_t evt_o
);
  localparam int unsigned NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b100; // cs_n high, mosi low, sck low

  logic [STAGES-1:0][NSIG-1:0] stg_q;
  logic [NSIG-1:0]             raw;
  logic [NSIG-1:0]             sync;
  logic                        sck_prev_q;

  assign raw  = {cs_n_i, mosi_i, sck_i};
  assign sync = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q      <= {STAGES{IDLE}};
      sck_prev_q <= 1'b0;
    end else begin
      stg_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_prev_q <= sync[0];
    end
  end

  always_comb begin
    evt_o.sck_rise = sync[0] & ~sck_prev_q;
    evt_o.sck_fall = ~sync[0] & sck_prev_q;
    evt_o.cs_act   = ~sync[2];
    evt_o.mosi     = sync[1];
  end
endmodule

// File: rtl/spi_dbuf_bitcnt.sv
module spi_dbuf_bitcnt #(
  parameter int unsigned W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  spi_dbuf_pkg::spi_evt_t evt_i,
  output logic                   sample_o,  // rising SCK inside frame
  output logic                   shift_o,   // falling SCK, not at byte start
  output logic                   done_o,    // last bit of byte sampled
  output logic                   load_ok_o  // next cycle is at a byte boundary
);
  localparam int unsigned   CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign sample_o = evt_i.cs_act & evt_i.sck_rise;
  assign shift_o  = evt_i.cs_act & evt_i.sck_fall & (cnt_q != '0);
  assign done_o   = sample_o & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!evt_i.cs_act)  cnt_d = '0;
    else if (done_o)    cnt_d = '0;
    else if (sample_o)  cnt_d = cnt_q + 1'b1;
  end

  assign load_ok_o = (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_dbuf_tx.sv
module spi_dbuf_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         shift_i,
  input  logic         done_i,
  input  logic         load_ok_i,
  output logic         miso_o,
  output logic         hold_empty_o,
  output logic         all_empty_o
);
  logic [W-1:0] hold_q, hold_d, sh_q, sh_d;
  logic         hv_q, hv_d, ld_q, ld_d;
  logic         upd;

  assign upd = wr_i | shift_i | done_i;

  always_comb begin
    hold_d = hold_q;
    hv_d   = hv_q;
    sh_d   = sh_q;
    ld_d   = ld_q;
    if (shift_i) sh_d = {sh_q[W-2:0], 1'b1};
    if (done_i) begin
      if (hv_q) begin
        sh_d = hold_q;
        ld_d = 1'b1;
        hv_d = 1'b0;
      end else begin
        sh_d = '1;
        ld_d = 1'b0;
      end
    end
    if (wr_i && !hv_q) begin
      if (!ld_d && load_ok_i) begin
        sh_d = wdata_i;
        ld_d = 1'b1;
      end else begin
        hold_d = wdata_i;
        hv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hv_q   <= 1'b0;
      sh_q   <= '1;
      ld_q   <= 1'b0;
    end else if (upd) begin
      hold_q <= hold_d;
      hv_q   <= hv_d;
      sh_q   <= sh_d;
      ld_q   <= ld_d;
    end
  end

  assign miso_o       = sh_q[W-1];
  assign hold_empty_o = ~hv_q;
  assign all_empty_o  = ~hv_q & ~ld_q;
endmodule

// File: rtl/spi_dbuf_rx.sv
module spi_dbuf_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_i,
  input  logic         done_i,
  input  logic         mosi_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         ready_o,
  output logic         overrun_o
);
  logic [W-1:0] sh_q, sh_d, dat_q, dat_d;
  logic         rdy_q, rdy_d, ovr_q, ovr_d;

  always_comb begin
    sh_d  = sh_q;
    dat_d = dat_q;
    rdy_d = rdy_q;
    ovr_d = ovr_q;
    if (sample_i) sh_d = {sh_q[W-2:0], mosi_i};
    if (rd_i) begin
      rdy_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (done_i) begin
      dat_d = {sh_q[W-2:0], mosi_i};
      rdy_d = 1'b1;
      if (rdy_q && !rd_i) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      dat_q <= '0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (sample_i | rd_i) begin
      sh_q  <= sh_d;
      dat_q <= dat_d;
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  assign data_o    = dat_q;
  assign ready_o   = rdy_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/spi_dbuf_slave.sv
module spi_dbuf_slave #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         host_rd,
  output logic [W-1:0] host_rdata,
  input  logic         spi_sck,
  input  logic         spi_mosi,
  input  logic         spi_cs_n,
  output logic         spi_miso,
  output logic         tx_hold_empty,
  output logic         tx_all_empty,
  output logic         rx_ready,
  output logic         rx_overrun,
  output logic         data_pending
);
  import spi_dbuf_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  spi_evt_t   evt;
  logic       sample, shift, done, load_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  spi_dbuf_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n_s), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_n_i(spi_cs_n), .evt_o(evt)
  );

  spi_dbuf_bitcnt #(.W(W)) i_cnt (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt), .sample_o(sample),
    .shift_o(shift), .done_o(done), .load_ok_o(load_ok)
  );

  spi_dbuf_tx #(.W(W)) i_tx (
    .clk(clk), .rst_n(rst_n_s), .wr_i(host_wr), .wdata_i(host_wdata),
    .shift_i(shift), .done_i(done), .load_ok_i(load_ok),
    .miso_o(spi_miso), .hold_empty_o(tx_hold_empty), .all_empty_o(tx_all_empty)
  );

  spi_dbuf_rx #(.W(W)) i_rx (
    .clk(clk), .rst_n(rst_n_s), .sample_i(sample), .done_i(done),
    .mosi_i(evt.mosi), .rd_i(host_rd), .data_o(host_rdata),
    .ready_o(rx_ready), .overrun_o(rx_overrun)
  );

  assign data_pending = ~tx_all_empty;
endmodule

// File: rtl/spi_dbuf_slave_chk.sv
module spi_dbuf_slave_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_wr,
  input logic         host_rd,
  input logic         tx_hold_empty,
  input logic         tx_all_empty,
  input logic         rx_ready,
  input logic         rx_overrun,
  input logic         data_pending
);
  AST_DRAINED_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_all_empty |-> tx_hold_empty);                                   // R7
  AST_WRITE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (!tx_all_empty && data_pending));                      // R2
  AST_HOLD_FILLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_hold_empty) |-> $past(host_wr));                          // R4
  AST_DRAIN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_all_empty) |-> $past(tx_hold_empty));                     // R7
  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !rx_overrun);                                          // R10
  AST_OVR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_ready);                                   // R10
endmodule

bind spi_dbuf_slave spi_dbuf_slave_chk #(.W(W)) i_chk (.*);

// File: tb/test_spi_dbuf_slave.sv
`timescale 1ns/1ps
module test_spi_dbuf_slave;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1, spi_miso;
  logic       tx_hold_empty, tx_all_empty, rx_ready, rx_overrun, data_pending;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the requirements
  bit       m_hv, m_ld, m_rdy, m_ovr, in_frame;
  bit [7:0] m_hold, m_sh, m_rx;

  always #2.5 clk = ~clk;

  spi_dbuf_slave i_spi_dbuf_slave (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_tx(input string req);
    check(tx_hold_empty == !m_hv, req, "tx_hold_empty", tx_hold_empty, !m_hv);
    check(tx_all_empty == (!m_hv && !m_ld), req, "tx_all_empty", tx_all_empty, !m_hv && !m_ld);
    check(data_pending == (m_hv || m_ld), req, "data_pending", data_pending, m_hv || m_ld);
  endtask

  task automatic host_write(input bit [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (!m_hv) begin
      if (!m_ld && !in_frame) begin m_sh = d; m_ld = 1; end
      else begin m_hold = d; m_hv = 1; end
    end
  endtask

  task automatic host_read();
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    m_rdy = 0; m_ovr = 0;
    check(rx_ready == 1'b0, "R10", "rx_ready after read", rx_ready, 0);
    check(rx_overrun == 1'b0, "R10", "rx_overrun after read", rx_overrun, 0);
  endtask

  task automatic frame(input bit [7:0] mo, input bit mid_wr, input bit [7:0] mid_d);
    bit [7:0] got, exp_tx;
    bit pend, pend_exp;
    spi_cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = mo[i];
      waitc(HALF);
      got[i] = spi_miso;
      if (i == 0) pend = data_pending;
      spi_sck = 1'b1;
      waitc(HALF);
      spi_sck = 1'b0;
      if (i == 5 && mid_wr) begin
        in_frame = 1;
        host_write(mid_d);
        in_frame = 0;
        check(tx_hold_empty == !m_hv, "R4", "hold flag mid-frame", tx_hold_empty, !m_hv);
      end
    end
    waitc(HALF);
    spi_cs_n = 1'b1;
    waitc(HALF);
    exp_tx   = m_ld ? m_sh : 8'hFF;
    pend_exp = m_ld || m_hv;
    if (m_hv) begin m_sh = m_hold; m_ld = 1; m_hv = 0; end
    else m_ld = 0;
    if (m_rdy) m_ovr = 1;
    m_rdy = 1; m_rx = mo;
    check(got == exp_tx, exp_tx == 8'hFF ? "R8" : "R5", "miso byte", got, exp_tx);
    check(pend == pend_exp, "R7", "data_pending before last edge", pend, pend_exp);
    check_tx("R7");
    check(host_rdata == m_rx, "R9", "host_rdata", host_rdata, m_rx);
    check(rx_ready == m_rdy, "R9", "rx_ready", rx_ready, m_rdy);
    check(rx_overrun == m_ovr, "R10", "rx_overrun", rx_overrun, m_ovr);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    waitc(4);
    rst_n = 1'b1;
    waitc(4);
    // R1 reset state
    check(tx_hold_empty == 1, "R1", "tx_hold_empty", tx_hold_empty, 1);
    check(tx_all_empty == 1, "R1", "tx_all_empty", tx_all_empty, 1);
    check(data_pending == 0, "R1", "data_pending", data_pending, 0);
    check(rx_ready == 0, "R1", "rx_ready", rx_ready, 0);
    check(rx_overrun == 0, "R1", "rx_overrun", rx_overrun, 0);
    check(spi_miso == 1, "R1", "spi_miso", spi_miso, 1);

    // R2 R3: direct load into the free shift register
    host_write(8'hA5);
    check(tx_all_empty == 0 && data_pending == 1, "R2", "busy after write", tx_all_empty, 0);
    check(tx_hold_empty == 1, "R3", "direct load leaves hold empty", tx_hold_empty, 1);
    // R4 second byte is held
    host_write(8'h3C);
    check(tx_hold_empty == 0, "R4", "second byte held", tx_hold_empty, 0);
    // R6 third byte ignored
    host_write(8'h77);
    check_tx("R6");
    frame(8'h81, 0, 0);   // sends A5, R5 transfer of 3C
    check(tx_hold_empty == 1, "R5", "hold empty after transfer", tx_hold_empty, 1);
    frame(8'h42, 0, 0);   // sends 3C (not 77), overrun R10
    check(tx_all_empty == 1, "R7", "drained after last byte", tx_all_empty, 1);
    host_read();
    frame(8'hC3, 0, 0);   // R8 filler
    host_read();
    frame(8'h5A, 1, 8'h96); // R4 mid-frame write is held, filler this frame
    frame(8'h00, 0, 0);   // sends 96
    host_read();

    for (int n = 0; n < 60; n++) begin
      int nw = $urandom % 4;
      for (int k = 0; k < nw; k++) begin
        host_write(8'($urandom));
        check_tx("R4");
      end
      frame(8'($urandom), ($urandom % 5) == 0, 8'($urandom));
      if ($urandom % 2) host_read();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule